// File: doc/BRIEF.md
# Timer Debug Clock-Enable Controller

This block decides, cycle by cycle, whether a timer's prescaler, its pulse accumulator and its input-pin synchronizers may advance. It holds a 16-bit configuration word written over a plain write strobe and data bus. It also watches a freeze request coming from a debug controller. From these it derives three enable strobes.

The block has four operating conditions:
- **Free running:** all three enables are high.
- **Full stop:** everything is held off.
- **Freeze:** the counters and synchronizers halt while the debug controller requests it, if software has opted in.
- **Single-step:** software halts the prescaler and then advances it one clock at a time by writing an increment bit. That bit clears itself.

The block contains the pin synchronizer chain itself. It reports a one-cycle event for every level change that leaves the chain. While stepping, it presents a held copy of the pin levels.

A capture event that the chain produced before a halt began still reaches the output during the halt. No new events enter while the chain is frozen.

Top module: `tmr_dbg_clken`

## Requirements
- R1: After synchronous reset the configuration word reads 0x0000, `presc_en`, `pacc_en` and `sync_en` are all 1, and `edge_evt` is all zeros.
- R2: `bus_rdata` returns the stored word. Bits 15 (full stop), 14 (spare, no function), 13 (freeze opt-in), 12 (prescaler halt), 7 (supervisor select) and 3..0 (arbitration ID) are written from `bus_wdata` when `bus_wr` is 1. Bit 11 follows R8 and R9. Bits 10..8 and 6..4 always read 0.
- R3: While bit 15 is 1, all three enables are 0. Clearing bit 15 restores them in the cycle after the write.
- R4: While bit 13 is 1 and `freeze_req` is 1, all three enables are 0, except during a step pulse (R8).
- R5: The freeze halt ends in the same cycle that `freeze_req` falls, or in the cycle after a write that clears bit 13.
- R6: An `edge_evt` bit registered at the last enabled synchronizer clock is still presented in the first frozen cycle. While frozen, the synchronizer chain does not shift, no new `edge_evt` appears, and `pin_view` does not follow `pin_in`.
- R7: While bit 12 is 1, `pacc_en` is 0 and `presc_en`/`sync_en` are 0 outside step pulses. `pin_view` returns the synchronized pin levels captured by the write that set bit 12 from 0.
- R8: A write whose data has bits 11 and 12 both set, made while stored bit 12 is already 1, causes a step. In the following cycle `presc_en` and `sync_en` are 1 for exactly one clock, `pacc_en` stays 0, and bit 11 reads 1. From the next cycle on, bit 11 reads 0. Repeated writes step again, and this also works during freeze.
- R9: A write with bit 11 set causes no step when stored bit 12 is 0 or the written bit 12 is 0. In that case bit 11 reads back 0 and no pulse appears.
- R10: Bit 15 overrides a step: a step write with bit 15 set leaves all enables at 0.
- R11: A level change on `pin_in[i]` sets `edge_evt[i]` for one cycle after `SYNC_DEPTH` enabled synchronizer clocks. `pin_view[i]` shows the new level in that same cycle when bit 12 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the configuration word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Configuration word readback |
| freeze_req | input | 1 | Freeze request from the debug controller |
| pin_in | input | NPIN | Asynchronous timer input pins |
| presc_en | output | 1 | Prescaler count enable |
| pacc_en | output | 1 | Pulse accumulator count enable |
| sync_en | output | 1 | Synchronizer clock enable |
| pin_view | output | NPIN | Synchronized or held pin levels |
| edge_evt | output | NPIN | One-cycle level-change events |

## Verification
The bench builds the block with `NPIN` = 3 and `SYNC_DEPTH` = 3. The three-stage chain gives an observable gap between a pin change and its event. That gap lets a freeze be placed exactly after the event is registered and before any later change arrives. The three pins are stepped in different phases, so each event can be attributed to one pin. The three-deep chain also needs three separate single steps before an event emerges, which shows that each step clocks the chain exactly once.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int CFG_W         = 16;
    localparam int BIT_STOP      = 15;
    localparam int BIT_FRZ_SPARE = 14;
    localparam int BIT_FRZ_EN    = 13;
    localparam int BIT_HALT_PS   = 12;
    localparam int BIT_STEP      = 11;
    localparam int BIT_SUPV      = 7;
    localparam int ARB_LSB       = 0;
    localparam int ARB_W         = 4;

    typedef struct packed {
        logic             stop;
        logic             frz_spare;
        logic             frz_en;
        logic             halt_ps;
        logic             step;
        logic             supv;
        logic [ARB_W-1:0] arb;
    } cfg_t;

    typedef struct packed {
        logic presc;
        logic pacc;
        logic sync;
    } clken_t;

    function automatic logic [CFG_W-1:0] cfg_pack(input cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[BIT_STOP]                  = c.stop;
        w[BIT_FRZ_SPARE]             = c.frz_spare;
        w[BIT_FRZ_EN]                = c.frz_en;
        w[BIT_HALT_PS]               = c.halt_ps;
        w[BIT_STEP]                  = c.step;
        w[BIT_SUPV]                  = c.supv;
        w[ARB_LSB +: ARB_W]          = c.arb;
        return w;
    endfunction

    function automatic cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.stop      = w[BIT_STOP];
        c.frz_spare = w[BIT_FRZ_SPARE];
        c.frz_en    = w[BIT_FRZ_EN];
        c.halt_ps   = w[BIT_HALT_PS];
        c.step      = w[BIT_STEP];
        c.supv      = w[BIT_SUPV];
        c.arb       = w[ARB_LSB +: ARB_W];
        return c;
    endfunction

endpackage

// File: rtl/tdc_cfg_reg.sv
module tdc_cfg_reg
    import tdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q,
    output logic             halt_set,
    output logic [CFG_W-1:0] rdata
);

    cfg_t wr_val;

    always_comb begin
        wr_val      = cfg_unpack(wdata);
        // step is armed only while the halt is already held and stays held
        wr_val.step = wdata[BIT_STEP] & wdata[BIT_HALT_PS] & cfg_q.halt_ps;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_val;
        end else begin
            cfg_q.step <= 1'b0;
        end
    end

    assign halt_set = wr_en & wdata[BIT_HALT_PS] & ~cfg_q.halt_ps;
    assign rdata    = cfg_pack(cfg_q);

endmodule

// File: rtl/tdc_gate.sv
module tdc_gate
    import tdc_pkg::*;
(
    input  cfg_t   cfg,
    input  logic   freeze_req,
    output clken_t en
);

    logic frozen;
    logic halted;
    logic stepping;

    always_comb begin
        frozen   = cfg.frz_en & freeze_req;
        halted   = frozen | cfg.halt_ps;
        stepping = cfg.step & cfg.halt_ps;
        en.presc = ~cfg.stop & (~halted | stepping);
        en.sync  = ~cfg.stop & (~halted | stepping);
        en.pacc  = ~cfg.stop & ~halted;
    end

endmodule

// File: rtl/tdc_pin_sync.sv
module tdc_pin_sync #(
    parameter int NPIN       = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_en,
    input  logic            hold_active,
    input  logic            hold_load,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_view,
    output logic [NPIN-1:0] edge_evt
);

    localparam int LAST = SYNC_DEPTH - 1;

    logic [NPIN-1:0] synced;
    logic [NPIN-1:0] held;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [SYNC_DEPTH-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain       <= '0;
                edge_evt[g] <= 1'b0;
            end else if (sync_en) begin
                chain       <= {chain[LAST-1:0], pin_in[g]};
                edge_evt[g] <= chain[LAST-1] ^ chain[LAST];
            end else begin
                edge_evt[g] <= 1'b0;
            end
        end

        assign synced[g] = chain[LAST];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (hold_load) begin
            held <= synced;
        end
    end

    assign pin_view = hold_active ? held : synced;

endmodule

// File: rtl/tmr_dbg_clken.sv
module tmr_dbg_clken
    import tdc_pkg::*;
#(
    parameter int NPIN       = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [CFG_W-1:0] bus_wdata,
    output logic [CFG_W-1:0] bus_rdata,
    input  logic             freeze_req,
    input  logic [NPIN-1:0]  pin_in,
    output logic             presc_en,
    output logic             pacc_en,
    output logic             sync_en,
    output logic [NPIN-1:0]  pin_view,
    output logic [NPIN-1:0]  edge_evt
);

    cfg_t   cfg_q;
    logic   halt_set;
    clken_t en;

    tdc_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .wdata    (bus_wdata),
        .cfg_q    (cfg_q),
        .halt_set (halt_set),
        .rdata    (bus_rdata)
    );

    tdc_gate u_gate (
        .cfg        (cfg_q),
        .freeze_req (freeze_req),
        .en         (en)
    );

    tdc_pin_sync #(
        .NPIN       (NPIN),
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk         (clk),
        .rst         (rst),
        .sync_en     (en.sync),
        .hold_active (cfg_q.halt_ps),
        .hold_load   (halt_set),
        .pin_in      (pin_in),
        .pin_view    (pin_view),
        .edge_evt    (edge_evt)
    );

    assign presc_en = en.presc;
    assign pacc_en  = en.pacc;
    assign sync_en  = en.sync;

endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
    parameter int NPIN = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_wr,
    input logic [15:0]     bus_wdata,
    input logic [15:0]     bus_rdata,
    input logic            freeze_req,
    input logic            presc_en,
    input logic            pacc_en,
    input logic            sync_en,
    input logic [NPIN-1:0] edge_evt
);

    AST_STOP_GATES: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[15] |-> (!presc_en && !pacc_en && !sync_en)); // R3

    AST_FREEZE_HALT: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[13] && freeze_req && !bus_rdata[11]) |-> (!presc_en && !pacc_en && !sync_en)); // R4

    AST_HALT_PACC: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[12] |-> !pacc_en); // R7

    AST_HALT_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[12] && presc_en) |-> bus_rdata[11]); // R8

    AST_STEP_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[11] && !bus_wr) |=> !bus_rdata[11]); // R8

    AST_NO_IDLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rdata[12]) |=> !bus_rdata[11]); // R9

    AST_NO_STEP_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_wdata[12]) |=> !bus_rdata[11]); // R9

    AST_EVT_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (edge_evt != '0) |-> $past(sync_en)); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[10:8] == 3'b000) && (bus_rdata[6:4] == 3'b000)); // R2

endmodule

bind tmr_dbg_clken tdc_checker #(.NPIN(NPIN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .freeze_req (freeze_req),
    .presc_en   (presc_en),
    .pacc_en    (pacc_en),
    .sync_en    (sync_en),
    .edge_evt   (edge_evt)
);

// File: tb/sim_tmr_dbg_clken.sv
`timescale 1ns/1ps
module sim_tmr_dbg_clken;

    localparam int NPIN  = 3;
    localparam int DEPTH = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata;
    logic            freeze_req = 1'b0;
    logic [NPIN-1:0] pin_in = '0;
    logic            presc_en, pacc_en, sync_en;
    logic [NPIN-1:0] pin_view, edge_evt;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    tmr_dbg_clken #(.NPIN(NPIN), .SYNC_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .freeze_req(freeze_req), .pin_in(pin_in),
        .presc_en(presc_en), .pacc_en(pacc_en), .sync_en(sync_en),
        .pin_view(pin_view), .edge_evt(edge_evt)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] wdata;
        logic        frz;
        logic [2:0]  en;   // {presc, pacc, sync}
        logic [15:0] rd;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 16'h0000, 1'b0, 3'b111, 16'h0000}, // R1 idle
        '{1'b1, 16'h2000, 1'b0, 3'b111, 16'h2000}, // R2 opt-in only
        '{1'b0, 16'h0000, 1'b1, 3'b000, 16'h2000}, // R4 frozen
        '{1'b0, 16'h0000, 1'b0, 3'b111, 16'h2000}, // R5 request falls
        '{1'b0, 16'h0000, 1'b1, 3'b000, 16'h2000}, // R4 frozen again
        '{1'b1, 16'h0000, 1'b1, 3'b111, 16'h0000}, // R5 opt-in cleared
        '{1'b1, 16'h1000, 1'b0, 3'b000, 16'h1000}, // R7 halt
        '{1'b1, 16'h1800, 1'b0, 3'b101, 16'h1800}, // R8 step
        '{1'b0, 16'h0000, 1'b0, 3'b000, 16'h1000}, // R8 self clear
        '{1'b1, 16'h1800, 1'b0, 3'b101, 16'h1800}, // R8 second step
        '{1'b1, 16'h0800, 1'b0, 3'b111, 16'h0000}, // R9 halt dropped
        '{1'b1, 16'h0800, 1'b0, 3'b111, 16'h0000}, // R9 not halted
        '{1'b1, 16'h3000, 1'b1, 3'b000, 16'h3000}, // R4 freeze plus halt
        '{1'b1, 16'h3800, 1'b1, 3'b101, 16'h3800}, // R8 step while frozen
        '{1'b0, 16'h0000, 1'b1, 3'b000, 16'h3000}, // R4 back to frozen
        '{1'b1, 16'h9000, 1'b0, 3'b000, 16'h9000}, // R3 full stop
        '{1'b1, 16'h9800, 1'b0, 3'b000, 16'h9800}, // R10 step blocked
        '{1'b0, 16'h0000, 1'b0, 3'b000, 16'h9000}, // R10 cleared
        '{1'b1, 16'hFFFF, 1'b0, 3'b000, 16'hF88F}, // R2 all ones
        '{1'b0, 16'h0000, 1'b0, 3'b000, 16'hF08F}, // R2 step bit gone
        '{1'b1, 16'h0000, 1'b0, 3'b111, 16'h0000}, // R3 released
        '{1'b1, 16'h008A, 1'b0, 3'b111, 16'h008A}, // R2 supv and id
        '{1'b1, 16'h4000, 1'b0, 3'b111, 16'h4000}, // R2 spare bit
        '{1'b1, 16'h0000, 1'b0, 3'b111, 16'h0000}  // R2 clear
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [15:0] d);
        bus_wr    = 1'b1;
        bus_wdata = d;
        tick();
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    initial begin
        #800000;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 rdata", bus_rdata, 16'h0000);
        check("R1 enables", {presc_en, pacc_en, sync_en}, 3'b111);
        check("R1 edge_evt", edge_evt, '0);

        for (int i = 0; i < NV; i++) begin
            bus_wr     = TBL[i].wr;
            bus_wdata  = TBL[i].wdata;
            freeze_req = TBL[i].frz;
            tick();
            check($sformatf("row %0d enables", i), {presc_en, pacc_en, sync_en}, TBL[i].en);
            check($sformatf("row %0d rdata", i), bus_rdata, TBL[i].rd);
            bus_wr = 1'b0;
        end
        freeze_req = 1'b0;
        tick();

        // R11 event latency through the chain
        pin_in = 3'b001;
        for (int k = 0; k < DEPTH - 1; k++) tick();
        check("R11 no early event", edge_evt, 3'b000);
        tick();
        check("R11 event", edge_evt, 3'b001);
        check("R11 pin_view", pin_view, 3'b001);
        tick();
        check("R11 one cycle", edge_evt, 3'b000);

        // R6 in-flight event survives the freeze
        wr_cfg(16'h2000);
        pin_in = 3'b011;
        for (int k = 0; k < DEPTH; k++) tick();
        freeze_req = 1'b1;
        #1;
        check("R6 event kept", edge_evt, 3'b010);
        check("R6 sync off", sync_en, 1'b0);
        pin_in = 3'b111;
        for (int k = 0; k < 5; k++) tick();
        check("R6 no new event", edge_evt, 3'b000);
        check("R6 view frozen", pin_view, 3'b011);
        freeze_req = 1'b0;
        for (int k = 0; k < DEPTH; k++) tick();
        check("R5 resumed event", edge_evt, 3'b100);
        check("R5 resumed view", pin_view, 3'b111);
        wr_cfg(16'h0000);

        // R7 held pin view, R8 single steps clock the chain
        wr_cfg(16'h1000);
        pin_in = 3'b000;
        for (int k = 0; k < 5; k++) tick();
        check("R7 view held", pin_view, 3'b111);
        check("R7 no event", edge_evt, 3'b000);
        for (int s = 0; s < DEPTH; s++) begin
            wr_cfg(16'h1800);
            check("R8 step pulse", {presc_en, pacc_en, sync_en}, 3'b101);
            tick();
            check("R8 pulse ends", {presc_en, pacc_en, sync_en}, 3'b000);
        end
        check("R8 event after steps", edge_evt, 3'b111);
        check("R7 view still held", pin_view, 3'b111);
        wr_cfg(16'h0000);
        check("R7 view released", pin_view, 3'b000);

        // R1 reset from a busy state
        wr_cfg(16'h9F8F);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check("R1 rdata after reset", bus_rdata, 16'h0000);
        check("R1 enables after reset", {presc_en, pacc_en, sync_en}, 3'b111);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule